// File: doc/BRIEF.md
# Buffered SPI Host with Interrupt Flags

This block is a host-side SPI serializer with one byte of transmit staging and a two-byte receive queue. Software loads bytes through a small register bus. Each byte moves from the staging slot into the shifter as soon as the link is idle. The received byte is pushed into the queue when the last clock pulse finishes. Five status flags track what happened, and an interrupt line reports any flag whose enable bit is set.

The serial side runs mode 0. SCK idles low, MOSI carries the most significant bit first, and MISO is sampled on each rising SCK edge. The SCK half period is a fixed count of system clocks. While in host mode, the block watches the select pin. If another host pulls it low, the block drops to client mode and stops driving transfers. Software can block this fallback with an ignore input, and it returns the block to host mode through a register write.

Top module: `spib_core`

## Requirements
- R1: After a synchronous reset the flag register reads 0x20 (only the transmit-empty flag set), the enable register reads 0x00, the mode register reads 0x01 (host), SCK is low and the interrupt output is low.
- R2: In host mode a byte written to the data register (address 0) is sent on MOSI MSB first, with eight SCK pulses that idle low. MISO is sampled on each rising SCK edge, and the sampled byte is queued for reading.
- R3: Flag bit 5 (transmit-empty) reads 0 from a data write until that byte enters the shifter, and reads 1 at all other times. Writing a 1 to bit 5 has no effect.
- R4: Flag bit 7 (receive-ready) sets when a byte enters the receive queue. A data read returns the oldest queued byte and removes it. Bit 7 stays set until the queue is empty, or until a 1 is written to bit 7.
- R5: Flag bit 6 (transfer-done) sets when a transfer ends and no byte is waiting in the staging slot. It does not set between back-to-back bytes, and only writing a 1 to bit 6 clears it.
- R6: In host mode with the ignore input low, a low level on the select pin moves the block to client mode and sets flag bit 4. Client mode starts no transfers. Writing a 1 to bit 4 clears the flag. Writing 1 to bit 0 of the mode register (address 3) restores host mode. With the ignore input high, the select pin is ignored.
- R7: A byte that completes while both queue entries are full is discarded, and the queued bytes are kept. Flag bit 0 (overflow) for that loss rises when the next transfer starts. It clears on a data read or when a 1 is written to bit 0.
- R8: Writing 0s to the flag register (address 1) changes nothing, and bits 3 to 1 always read 0. A hardware set event wins over a write-one-to-clear in the same cycle.
- R9: The interrupt output is the registered OR of each flag ANDed with the matching bit of the enable register (address 2, read/write). It follows the flags one cycle later.
- R10: All register reads are registered. Read data appears in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 data, 1 flags, 2 enables, 3 mode |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| sck_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_i | input | 1 | External select pin, active low |
| ss_ignore_i | input | 1 | High blocks the host-to-client fallback |
| host_mode_o | output | 1 | High while acting as host |
| irq_o | output | 1 | Interrupt request |

## Verification
Bus reads return data one cycle after the strobe. A flag register write takes effect at the same edge. The interrupt line follows a flag or enable change by one further cycle. The bench samples at the falling edge after each of these points. A transfer takes sixteen half periods plus a load cycle. The select-pin fallback needs two synchronizer stages plus one register. For these longer paths the bench does not fix a cycle. It polls the flag register over a bounded window, or it waits a fixed margin past the latest due cycle before it looks.

// File: rtl/spib_pkg.sv
package spib_pkg;
  localparam int FLAG_W = 8;
  localparam int F_RXC = 7;
  localparam int F_TXC = 6;
  localparam int F_DRE = 5;
  localparam int F_SSI = 4;
  localparam int F_OVF = 0;
  localparam logic [FLAG_W-1:0] FLAG_IMPL = 8'hF1;
  localparam logic [FLAG_W-1:0] FLAG_W1C  = 8'hD1;
  localparam logic [FLAG_W-1:0] FLAG_RST  = 8'h20;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_FLAG = 2'd1,
    REG_IEN  = 2'd2,
    REG_MODE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/spib_shift_engine.sv
module spib_shift_engine #(
  parameter int DW       = 8,
  parameter int HALF_DIV = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] load_byte,
  input  logic          abort,
  input  logic          miso_i,
  output logic          sck_o,
  output logic          mosi_o,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_byte
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  logic [CW-1:0] div_q;
  logic [BW-1:0] bit_q;
  logic [DW-1:0] tx_sh, rx_sh;
  logic          sck_q, busy_q, done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      bit_q  <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      sck_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort) begin
        busy_q <= 1'b0;
        sck_q  <= 1'b0;
      end else if (start) begin
        busy_q <= 1'b1;
        tx_sh  <= load_byte;
        div_q  <= '0;
        bit_q  <= '0;
        sck_q  <= 1'b0;
      end else if (busy_q) begin
        if (div_q == CW'(HALF_DIV - 1)) begin
          div_q <= '0;
          sck_q <= ~sck_q;
          if (!sck_q) begin
            rx_sh <= {rx_sh[DW-2:0], miso_i};
          end else begin
            tx_sh <= tx_sh << 1;
            if (bit_q == BW'(DW - 1)) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign sck_o   = sck_q;
  assign mosi_o  = tx_sh[DW-1];
  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = rx_sh;
endmodule

// File: rtl/spib_rx_fifo.sv
module spib_rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       accept,
  output logic                       drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          full, empty, do_pop;

  assign full   = (cnt == CW'(DEPTH));
  assign empty  = (cnt == '0);
  assign do_pop = pop && !empty;
  assign accept = push && (!full || do_pop);
  assign drop   = push && full && !do_pop;

  always_ff @(posedge clk) begin
    if (accept) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (accept) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({accept, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head  = mem[rptr];
  assign count = cnt;
endmodule

// File: rtl/spib_flag_regs.sv
module spib_flag_regs #(
  parameter int             FW      = 8,
  parameter logic [FW-1:0]  RST_VAL = '0,
  parameter logic [FW-1:0]  IMPL    = '1,
  parameter logic [FW-1:0]  W1C     = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] hw_set,
  input  logic [FW-1:0] hw_clr,
  input  logic          w1c_en,
  input  logic [FW-1:0] w1c_bits,
  output logic [FW-1:0] flags_q
);
  for (genvar i = 0; i < FW; i++) begin : g_bit
    if (IMPL[i]) begin : g_reg
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst)                                          bit_q <= RST_VAL[i];
        else if (hw_set[i])                               bit_q <= 1'b1;
        else if (hw_clr[i] || (w1c_en && W1C[i] && w1c_bits[i])) bit_q <= 1'b0;
      end
      assign flags_q[i] = bit_q;
    end else begin : g_tie
      logic unused_in;
      assign unused_in  = hw_set[i] ^ hw_clr[i] ^ w1c_bits[i];
      assign flags_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/spib_core.sv
module spib_core
  import spib_pkg::*;
#(
  parameter int DW          = 8,
  parameter int RX_DEPTH    = 2,
  parameter int HALF_DIV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          sck_o,
  output logic          mosi_o,
  input  logic          miso_i,
  input  logic          ss_n_i,
  input  logic          ss_ignore_i,
  output logic          host_mode_o,
  output logic          irq_o
);
  localparam int CNTW = $clog2(RX_DEPTH + 1);

  // bus decode
  logic data_wr, data_rd, flag_wr, ien_wr, mode_wr;
  assign data_wr = bus_wr && (bus_addr == REG_DATA);
  assign data_rd = bus_rd && (bus_addr == REG_DATA);
  assign flag_wr = bus_wr && (bus_addr == REG_FLAG);
  assign ien_wr  = bus_wr && (bus_addr == REG_IEN);
  assign mode_wr = bus_wr && (bus_addr == REG_MODE);

  // select pin synchronizer and mode
  logic [SYNC_STAGES-1:0] ss_sync;
  logic host_q, fallback;
  always_ff @(posedge clk) begin
    if (rst) ss_sync <= '1;
    else     ss_sync <= {ss_sync[SYNC_STAGES-2:0], ss_n_i};
  end
  assign fallback = host_q && !ss_sync[SYNC_STAGES-1] && !ss_ignore_i;

  always_ff @(posedge clk) begin
    if (rst)                          host_q <= 1'b1;
    else if (fallback)                host_q <= 1'b0;
    else if (mode_wr && bus_wdata[0]) host_q <= 1'b1;
  end

  // transmit staging slot
  logic          tx_full_q, busy, done, start;
  logic [DW-1:0] tx_buf_q, rx_byte;
  assign start = host_q && !fallback && !busy && tx_full_q;

  always_ff @(posedge clk) begin
    if (data_wr) tx_buf_q <= bus_wdata;
  end
  always_ff @(posedge clk) begin
    if (rst)          tx_full_q <= 1'b0;
    else if (data_wr) tx_full_q <= 1'b1;
    else if (start)   tx_full_q <= 1'b0;
  end

  spib_shift_engine #(.DW(DW), .HALF_DIV(HALF_DIV)) eng_i (
    .clk(clk), .rst(rst), .start(start), .load_byte(tx_buf_q), .abort(fallback),
    .miso_i(miso_i), .sck_o(sck_o), .mosi_o(mosi_o), .busy(busy), .done(done),
    .rx_byte(rx_byte)
  );

  // receive queue
  logic [DW-1:0]   rx_head;
  logic [CNTW-1:0] rx_cnt;
  logic            rx_accept, rx_drop;
  spib_rx_fifo #(.W(DW), .DEPTH(RX_DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .push(done), .wdata(rx_byte), .pop(data_rd),
    .head(rx_head), .count(rx_cnt), .accept(rx_accept), .drop(rx_drop)
  );

  // overflow deferred to the next transfer start
  logic ovf_pend_q, ovf_set, txc_set;
  assign ovf_set = start && (ovf_pend_q || rx_drop);
  assign txc_set = done && !tx_full_q;
  always_ff @(posedge clk) begin
    if (rst)          ovf_pend_q <= 1'b0;
    else if (start)   ovf_pend_q <= 1'b0;
    else if (rx_drop) ovf_pend_q <= 1'b1;
  end

  // flag register
  logic [FLAG_W-1:0] hw_set, hw_clr, flags_q;
  always_comb begin
    hw_set = '0;
    hw_clr = '0;
    hw_set[F_RXC] = rx_accept;
    hw_clr[F_RXC] = data_rd && (rx_cnt == CNTW'(1)) && !rx_accept;
    hw_set[F_TXC] = txc_set;
    hw_set[F_DRE] = start && !data_wr;
    hw_clr[F_DRE] = data_wr;
    hw_set[F_SSI] = fallback;
    hw_set[F_OVF] = ovf_set;
    hw_clr[F_OVF] = data_rd;
  end

  spib_flag_regs #(.FW(FLAG_W), .RST_VAL(FLAG_RST), .IMPL(FLAG_IMPL), .W1C(FLAG_W1C)) flg_i (
    .clk(clk), .rst(rst), .hw_set(hw_set), .hw_clr(hw_clr), .w1c_en(flag_wr),
    .w1c_bits(bus_wdata[FLAG_W-1:0]), .flags_q(flags_q)
  );

  // enables, interrupt, read data
  logic [FLAG_W-1:0] ien_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q     <= '0;
      irq_o     <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (ien_wr) ien_q <= bus_wdata[FLAG_W-1:0];
      irq_o <= |(flags_q & ien_q);
      if (bus_rd) begin
        case (reg_sel_e'(bus_addr))
          REG_DATA: bus_rdata <= (rx_cnt != '0) ? rx_head : '0;
          REG_FLAG: bus_rdata <= DW'(flags_q);
          REG_IEN:  bus_rdata <= DW'(ien_q);
          default:  bus_rdata <= DW'(host_q);
        endcase
      end
    end
  end

  assign host_mode_o = host_q;
endmodule

// File: rtl/spib_core_chk.sv
module spib_core_chk #(
  parameter int CNTW = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [7:0]      flags_q,
  input logic [7:0]      ien_q,
  input logic            irq_o,
  input logic            host_q,
  input logic            busy,
  input logic            sck_o,
  input logic [CNTW-1:0] rx_cnt,
  input logic            txc_set,
  input logic            ovf_set,
  input logic            start,
  input logic            data_rd,
  input logic            data_wr
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (flags_q == 8'h20 && !irq_o && host_q)); // R1
  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (rst) !busy |-> !sck_o); // R2
  AST_DRE_LOW_AFTER_WR: assert property (@(posedge clk) disable iff (rst) data_wr |=> !flags_q[5]); // R3
  AST_RXC_EMPTY: assert property (@(posedge clk) disable iff (rst) (rx_cnt == '0) |-> !flags_q[7]); // R4
  AST_FALLBACK_FLAG: assert property (@(posedge clk) disable iff (rst) $fell(host_q) |-> flags_q[4]); // R6
  AST_OVF_AT_START: assert property (@(posedge clk) disable iff (rst) $rose(flags_q[0]) |-> $past(start)); // R7
  AST_OVF_READ_CLR: assert property (@(posedge clk) disable iff (rst) (data_rd && !ovf_set) |=> !flags_q[0]); // R7
  AST_TXC_SET_WINS: assert property (@(posedge clk) disable iff (rst) txc_set |=> flags_q[6]); // R8
  AST_NO_EN_NO_IRQ: assert property (@(posedge clk) disable iff (rst) (ien_q == 8'h00) |=> !irq_o); // R9
endmodule

bind spib_core spib_core_chk #(.CNTW(CNTW)) chk_i (
  .clk(clk), .rst(rst), .flags_q(flags_q), .ien_q(ien_q), .irq_o(irq_o),
  .host_q(host_q), .busy(busy), .sck_o(sck_o), .rx_cnt(rx_cnt), .txc_set(txc_set),
  .ovf_set(ovf_set), .start(start), .data_rd(data_rd), .data_wr(data_wr)
);

// File: tb/spib_core_tb_top.sv
`timescale 1ns/1ps
module spib_core_tb_top;
  localparam logic [1:0] A_DATA = 2'd0, A_FLAG = 2'd1, A_IEN = 2'd2, A_MODE = 2'd3;
  // tx byte, expected rx byte (bench loops MISO back inverted)
  localparam logic [15:0] VEC [6] = '{16'hA55A, 16'h00FF, 16'hFF00, 16'h3CC3, 16'h817E, 16'h6D92};

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic sck, mosi, miso, ss_n = 1'b1, ss_ign = 1'b0, host_mode, irq;
  int n_chk = 0, n_fail = 0, sck_rises = 0;
  logic [7:0] mosi_cap = '0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  assign miso = ~mosi;

  spib_core dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso), .ss_n_i(ss_n), .ss_ignore_i(ss_ign), .host_mode_o(host_mode), .irq_o(irq)
  );

  always @(posedge sck) begin
    mosi_cap  <= {mosi_cap[6:0], mosi};
    sck_rises <= sck_rises + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_flags(input logic [7:0] mask, input string req);
    logic [7:0] f;
    bit ok = 1'b0;
    for (int i = 0; i < 400 && !ok; i++) begin
      rd(A_FLAG, f);
      ok = ((f & mask) == mask);
    end
    chk(req, ok, 1'b1);
  endtask

  task automatic overflow_case(input bit by_read);
    logic [7:0] v;
    wr(A_FLAG, 8'hFF);
    wr(A_DATA, 8'h11);
    wr(A_DATA, 8'h22);
    wait_flags(8'h20, "R7 room for third");
    wr(A_DATA, 8'h33);
    wait_flags(8'h40, "R7 third done");
    rd(A_FLAG, v); chk("R7 overflow deferred while idle", v, 8'hE0);
    wr(A_FLAG, 8'h40);
    wr(A_DATA, 8'h44);
    rd(A_FLAG, v); chk("R7 overflow at next start", v & 8'h01, 8'h01);
    if (by_read) begin
      rd(A_DATA, v); chk("R7 oldest kept", v, 8'hEE);
      rd(A_FLAG, v); chk("R7 data read clears overflow", v & 8'h01, 8'h00);
    end else begin
      wr(A_FLAG, 8'h01);
      rd(A_FLAG, v); chk("R7 write-one clears overflow", v & 8'h01, 8'h00);
      rd(A_DATA, v); chk("R7 oldest kept", v, 8'hEE);
    end
    rd(A_DATA, v); chk("R7 second kept", v, 8'hDD);
    wait_flags(8'h40, "R7 fourth done");
    rd(A_DATA, v); chk("R7 fourth received", v, 8'hBB);
    rd(A_FLAG, v); chk("R7 no new overflow", v & 8'h01, 8'h00);
  endtask

  initial begin
    logic [7:0] v;
    int r0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 host mode", host_mode, 1'b1);
    chk("R1 irq low", irq, 1'b0);
    chk("R1 sck low", sck, 1'b0);
    rd(A_FLAG, v); chk("R1 flags", v, 8'h20);
    rd(A_IEN, v);  chk("R1 enables", v, 8'h00);
    rd(A_MODE, v); chk("R1 mode reg R10", v, 8'h01);
    chk("R9 irq with no enables", irq, 1'b0);

    // table walk: R2, R4, R5
    for (int i = 0; i < 6; i++) begin
      wr(A_FLAG, 8'h40);
      r0 = sck_rises;
      wr(A_DATA, VEC[i][15:8]);
      wait_flags(8'h40, "R5 transfer done");
      chk("R2 mosi msb first", mosi_cap, VEC[i][15:8]);
      chk("R2 eight clocks", sck_rises - r0, 8);
      rd(A_FLAG, v); chk("R4 R5 flags after byte", v, 8'hE0);
      rd(A_DATA, v); chk("R2 received byte", v, VEC[i][7:0]);
      rd(A_FLAG, v); chk("R4 ready clears when empty", v, 8'h60);
    end

    // R8 zero write, R3 bit 5 not writable
    wr(A_FLAG, 8'h00);
    rd(A_FLAG, v); chk("R8 zero write no effect", v, 8'h60);
    wr(A_FLAG, 8'hFF);
    rd(A_FLAG, v); chk("R3 R8 write-ones keep empty flag", v, 8'h20);

    // back-to-back bytes: R3, R5, R4
    wr(A_DATA, 8'h12);
    wr(A_DATA, 8'h34);
    rd(A_FLAG, v); chk("R3 empty flag low while staged", v & 8'h20, 8'h00);
    wr(A_FLAG, 8'h20);
    rd(A_FLAG, v); chk("R3 write-one ignored", v & 8'h20, 8'h00);
    wait_flags(8'h80, "R4 first byte in");
    rd(A_FLAG, v); chk("R5 no done between chained bytes", v & 8'h40, 8'h00);
    wait_flags(8'h40, "R5 chain done");
    rd(A_DATA, v); chk("R4 oldest first", v, 8'hED);
    rd(A_FLAG, v); chk("R4 ready held with one left", v & 8'h80, 8'h80);
    rd(A_DATA, v); chk("R4 second byte", v, 8'hCB);
    rd(A_FLAG, v); chk("R4 ready clear when empty", v & 8'h80, 8'h00);

    // R4 write-one clear of ready
    wr(A_DATA, 8'hF0);
    wait_flags(8'h80, "R4 byte in");
    wr(A_FLAG, 8'h80);
    rd(A_FLAG, v); chk("R4 write-one clears ready", v & 8'h80, 8'h00);
    rd(A_DATA, v); chk("R4 data still readable", v, 8'h0F);

    // R7 both clear paths
    overflow_case(1'b1);
    overflow_case(1'b0);

    // R6 select fallback
    wr(A_FLAG, 8'hFF);
    ss_ign = 1'b1; ss_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R6 ignore keeps host", host_mode, 1'b1);
    rd(A_FLAG, v); chk("R6 ignore no flag", v & 8'h10, 8'h00);
    ss_ign = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 fallback to client", host_mode, 1'b0);
    rd(A_FLAG, v); chk("R6 select flag set", v & 8'h10, 8'h10);
    rd(A_MODE, v); chk("R6 mode reg client", v, 8'h00);
    r0 = sck_rises;
    wr(A_DATA, 8'h5A);
    repeat (60) @(negedge clk);
    chk("R6 no clocks in client mode", sck_rises - r0, 0);
    rd(A_FLAG, v); chk("R6 byte stays staged", v & 8'h20, 8'h00);
    wr(A_FLAG, 8'h10);
    rd(A_FLAG, v); chk("R6 write-one clears select flag", v & 8'h10, 8'h00);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
    wr(A_MODE, 8'h01);
    chk("R6 host restored", host_mode, 1'b1);
    wait_flags(8'h40, "R6 staged byte sent");
    chk("R6 staged byte on mosi", mosi_cap, 8'h5A);
    rd(A_DATA, v); chk("R6 staged byte received", v, 8'hA5);

    // R9 interrupt
    wr(A_FLAG, 8'hFF);
    wr(A_IEN, 8'h40);
    @(negedge clk);
    chk("R9 disabled-flag-only irq low", irq, 1'b0);
    wr(A_IEN, 8'h60);
    @(negedge clk);
    chk("R9 enabled empty flag raises irq", irq, 1'b1);
    rd(A_IEN, v); chk("R9 R10 enable readback", v, 8'h60);
    wr(A_IEN, 8'h00);
    @(negedge clk);
    chk("R9 irq drops", irq, 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule